// File: doc/BRIEF.md
# Cache-Aware Write Command Splitter

This block takes one memory-to-memory move request and turns its write side into a sequence of bus write transactions. A request carries a source address, a destination address, a byte count, a cache line size in dwords and a maximum burst length in dwords. The block returns one transaction per handshake. Each transaction has a command code, a start address, a byte count, and byte-lane enables for its first and last data phase.

When the source and destination agree in their low three address bits, the block aligns the writes to cache lines. It sends a plain write up to the next line boundary, then one line-invalidating write for each whole line, then a plain write for the remainder. When the two addresses do not agree, no alignment is done and the whole move goes out as plain writes. In both cases plain writes are cut at the burst limit.

The block accepts a new request only while it is idle. A done flag pulses once after the last transaction of a move has been taken.

Top module: `wr_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and both `out_valid` and `done` are 0. `req_ready` is 1 only while no move is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` and `out_valid` are never high together.
- R2: A request with a byte count of zero produces no transaction. `done` is high for exactly the one cycle after the request is taken.
- R3: The first transaction of a move starts at the destination address. Each later transaction starts where the previous one ended. The byte counts of the transactions add up to the requested count.
- R4: Every transaction carries at least 1 byte and at most 4×burst bytes. A burst value of 0 is treated as 1 dword.
- R5: Line alignment is off when the cache line size is 0, when source and destination differ in address bits [2:0], or when 4×line size exceeds 4×burst. With alignment off, every transaction uses command code 4'b0111 and carries min(remaining, 4×burst) bytes.
- R6: With alignment on, the first transaction is a plain write (4'b0111) when the start address is not on a line boundary. It carries min(remaining, bytes to the boundary, 4×burst) bytes.
- R7: With alignment on, at a line-aligned address with at least one whole line left, the transaction uses command code 4'b1111 and carries exactly 4×line size bytes. When less than one line remains, the rest goes out as plain writes of min(remaining, 4×burst) bytes.
- R8: A line-invalidating transaction (4'b1111) always has all four lanes enabled in both enable fields, and its address is a multiple of the line size in bytes.
- R9: The lanes are little endian: enable bit i covers data bits [8i+7:8i], the byte at dword offset i. `out_be_first` enables the lanes of the first dword that lie inside the transaction. `out_be_last` enables the lanes of the last dword that lie inside the transaction. In a single-dword transaction the two fields are equal.
- R10: While `out_valid` is high and `out_ready` is low, the command, address, count and enables hold their values on the next cycle, and `out_valid` stays high.
- R11: `done` is high for exactly the one cycle after the handshake of the final transaction. It is never high together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Move request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_src | input | AW | Source byte address |
| req_dst | input | AW | Destination byte address |
| req_len | input | LW | Move length in bytes |
| req_line_dw | input | CW | Cache line size in dwords (power of two, 0 disables invalidation) |
| req_burst_dw | input | CW | Maximum transaction length in dwords |
| out_valid | output | 1 | Transaction presented |
| out_ready | input | 1 | Consumer takes the transaction |
| out_cmd | output | 4 | Command code: 4'b0111 plain write, 4'b1111 line-invalidating write |
| out_addr | output | AW | Transaction start byte address |
| out_len | output | LW | Transaction byte count |
| out_be_first | output | 4 | Lane enables of the first dword, bit i for byte i |
| out_be_last | output | 4 | Lane enables of the last dword, bit i for byte i |
| done | output | 1 | One-cycle pulse when a move is complete |

## Verification
The bench sweeps line sizes, burst limits (including 0), destination offsets across more than one line, and source offsets that do and do not match the destination in the low three bits. It also sweeps lengths that fall short of, land on, or run past line boundaries. It stalls the consumer at pseudo-random times. A design that tested line alignment on the wrong address bits would issue invalidating writes for mismatched pairs, or would miss them for pairs offset by 8. A head write that is not clipped to the boundary would push later invalidating writes off line alignment. Off-by-one errors in the enable logic would show up at the two-dword boundary and in single-byte transactions. A design that advanced its state on a stalled cycle, or that mishandled a zero-length request, would produce a skipped or repeated transaction, or a missing or doubled `done` pulse.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [3:0] {
    CMD_MW  = 4'b0111,
    CMD_MWI = 4'b1111
  } wcmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/wrs_chunk_calc.sv
module wrs_chunk_calc
  import wrs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] rem,
  input  logic          align_en,
  input  logic [LW-1:0] line_b,
  input  logic [LW-1:0] burst_b,
  output wcmd_e         cmd,
  output logic [LW-1:0] len
);
  logic [LW-1:0] off;
  logic [LW-1:0] to_bnd;
  logic [LW-1:0] cap;

  assign off    = addr[LW-1:0] & (line_b - LW'(1));
  assign to_bnd = line_b - off;
  assign cap    = (rem < burst_b) ? rem : burst_b;

  always_comb begin
    cmd = CMD_MW;
    len = cap;
    if (align_en) begin
      if (off == '0) begin
        if (rem >= line_b) begin
          cmd = CMD_MWI;
          len = line_b;
        end
      end else if (to_bnd < cap) begin
        len = to_bnd;
      end
    end
  end
endmodule

// File: rtl/wrs_byte_en.sv
module wrs_byte_en #(
  parameter int LW = 16
) (
  input  logic [1:0]    lo,
  input  logic [LW-1:0] len,
  output logic [3:0]    be_first,
  output logic [3:0]    be_last
);
  localparam int LANES = 4;

  logic [LW:0] span;
  logic        single;
  logic [2:0]  first_hi;
  logic [2:0]  last_lo;
  logic [2:0]  last_hi;

  assign span     = {{(LW-1){1'b0}}, lo} + {1'b0, len};
  assign single   = (span <= (LW+1)'(LANES));
  assign first_hi = single ? span[2:0] : 3'd4;
  assign last_lo  = single ? {1'b0, lo} : 3'd0;
  assign last_hi  = (span[1:0] == 2'd0) ? 3'd4 : {1'b0, span[1:0]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [2:0] LANE = 3'(i);
    assign be_first[i] = (LANE >= {1'b0, lo}) && (LANE < first_hi);
    assign be_last[i]  = (LANE >= last_lo) && (LANE < last_hi);
  end
endmodule

// File: rtl/wr_splitter.sv
module wr_splitter
  import wrs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic [LW-1:0] req_len,
  input  logic [CW-1:0] req_line_dw,
  input  logic [CW-1:0] req_burst_dw,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_cmd,
  output logic [AW-1:0] out_addr,
  output logic [LW-1:0] out_len,
  output logic [3:0]    out_be_first,
  output logic [3:0]    out_be_last,
  output logic          done
);
  localparam int DW_SHIFT = 2;

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [LW-1:0] lb_q, lb_d;
  logic [LW-1:0] bb_q, bb_d;
  logic          algn_q, algn_d;
  logic          done_q, done_d;
  logic          ctx_en;

  logic [LW-1:0] req_lb;
  logic [LW-1:0] req_bb;
  wcmd_e         ch_cmd;
  logic [LW-1:0] ch_len;
  logic          take_req;
  logic          take_out;

  assign req_lb   = LW'(req_line_dw) << DW_SHIFT;
  assign req_bb   = (req_burst_dw == '0) ? LW'(4) : (LW'(req_burst_dw) << DW_SHIFT);
  assign take_req = (st_q == ST_IDLE) && req_valid;
  assign take_out = (st_q == ST_RUN) && out_ready;

  wrs_chunk_calc #(.AW(AW), .LW(LW)) u_calc (
    .addr     (addr_q),
    .rem      (rem_q),
    .align_en (algn_q),
    .line_b   (lb_q),
    .burst_b  (bb_q),
    .cmd      (ch_cmd),
    .len      (ch_len)
  );

  wrs_byte_en #(.LW(LW)) u_be (
    .lo       (addr_q[1:0]),
    .len      (ch_len),
    .be_first (out_be_first),
    .be_last  (out_be_last)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    lb_d   = lb_q;
    bb_d   = bb_q;
    algn_d = algn_q;
    done_d = 1'b0;
    ctx_en = 1'b0;
    if (take_req) begin
      ctx_en = 1'b1;
      addr_d = req_dst;
      rem_d  = req_len;
      lb_d   = req_lb;
      bb_d   = req_bb;
      algn_d = (req_line_dw != '0) && (req_src[2:0] == req_dst[2:0]) && (req_lb <= req_bb);
      if (req_len == '0) begin
        done_d = 1'b1;
      end else begin
        st_d = ST_RUN;
      end
    end else if (take_out) begin
      ctx_en = 1'b1;
      addr_d = addr_q + AW'(ch_len);
      rem_d  = rem_q - ch_len;
      if (rem_q == ch_len) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      lb_q   <= '0;
      bb_q   <= LW'(4);
      algn_q <= 1'b0;
    end else if (ctx_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      lb_q   <= lb_d;
      bb_q   <= bb_d;
      algn_q <= algn_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_RUN);
  assign out_cmd   = ch_cmd;
  assign out_addr  = addr_q;
  assign out_len   = ch_len;
  assign done      = done_q;
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [3:0]    out_cmd,
  input logic [AW-1:0] out_addr,
  input logic [LW-1:0] out_len,
  input logic [3:0]    out_be_first,
  input logic [3:0]    out_be_last,
  input logic          done,
  input logic [LW-1:0] line_b,
  input logic [LW-1:0] burst_b
);
  // R1
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && out_valid));

  // R4
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= burst_b));

  // R8
  inval_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == 4'b1111) |-> (out_be_first == 4'hF) && (out_be_last == 4'hF));

  // R8
  inval_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == 4'b1111) |->
      ((out_addr[LW-1:0] & (line_b - LW'(1))) == '0) && (out_len == line_b));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_cmd) && $stable(out_addr)
      && $stable(out_len) && $stable(out_be_first) && $stable(out_be_last));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

bind wr_splitter wrs_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_cmd      (out_cmd),
  .out_addr     (out_addr),
  .out_len      (out_len),
  .out_be_first (out_be_first),
  .out_be_last  (out_be_last),
  .done         (done),
  .line_b       (lb_q),
  .burst_b      (bb_q)
);

// File: tb/wr_splitter_bench.sv
module wr_splitter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = 8;
  localparam int WATCHDOG = 190000;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_src;
  logic [AW-1:0] req_dst;
  logic [LW-1:0] req_len;
  logic [CW-1:0] req_line_dw;
  logic [CW-1:0] req_burst_dw;
  logic          out_valid;
  logic          out_ready;
  logic [3:0]    out_cmd;
  logic [AW-1:0] out_addr;
  logic [LW-1:0] out_len;
  logic [3:0]    out_be_first;
  logic [3:0]    out_be_last;
  logic          done;

  int n_chk;
  int n_fail;
  logic [7:0] lfsr;
  bit finished;

  wr_splitter #(.AW(AW), .LW(LW), .CW(CW)) u_wr_splitter (
    .clk, .rst_n, .req_valid, .req_ready, .req_src, .req_dst, .req_len,
    .req_line_dw, .req_burst_dw, .out_valid, .out_ready, .out_cmd, .out_addr,
    .out_len, .out_be_first, .out_be_last, .done
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_in(input longint base, input longint a, input longint n);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (base + i >= a) && (base + i < a + n);
    return r;
  endfunction

  task automatic run_case(input int src, input int dst, input int len, input int ldw, input int bdw);
    int a;
    int r;
    int lb;
    int bb;
    bit al;
    int n;
    int cmd;
    int off;
    int sum;
    int last;
    lb = ldw * 4;
    bb = (bdw == 0) ? 4 : bdw * 4;
    al = (ldw != 0) && ((src % 8) == (dst % 8)) && (lb <= bb);
    @(negedge clk);
    chk("R1 idle ready", req_ready, 1);
    req_valid = 1'b1; req_src = AW'(src); req_dst = AW'(dst); req_len = LW'(len);
    req_line_dw = CW'(ldw); req_burst_dw = CW'(bdw);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk("R2 zero-length done", done, 1);
      chk("R2 zero-length no output", out_valid, 0);
    end else begin
      a = dst; r = len; sum = 0;
      while (r > 0) begin
        chk("R1 busy not ready", req_ready, 0);
        chk("R11 no early done", done, 0);
        n = (r < bb) ? r : bb; cmd = 4'b0111;
        if (al) begin
          off = a % lb;
          if (off == 0 && r >= lb) begin n = lb; cmd = 4'b1111; end
          else if (off != 0 && lb - off < n) n = lb - off;
        end
        chk(al ? "R6 R7 command" : "R5 command", out_cmd, cmd);
        chk("R3 address", out_addr, a);
        chk(al ? "R6 R7 length" : "R4 R5 length", out_len, n);
        last = a + n - 1;
        chk("R9 first lanes", out_be_first, lanes_in(a - a % 4, a, n));
        chk("R9 last lanes", out_be_last, lanes_in(last - last % 4, a, n));
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[2];
        if (out_ready) begin a += n; r -= n; sum += n; end
        @(posedge clk);
        @(negedge clk);
        if (r > 0) chk("R10 valid held", out_valid, 1);
      end
      out_ready = 1'b0;
      chk("R3 total bytes", sum, len);
      chk("R11 done after last", done, 1);
      chk("R11 idle after last", out_valid, 0);
    end
    @(negedge clk);
    chk("R2 R11 done single cycle", done, 0);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < WATCHDOG && !finished; wd++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lines[4];
    int bursts[3];
    int lens[12];
    int sdel[3];
    lines = '{0, 2, 4, 8};
    bursts = '{0, 2, 16};
    lens = '{0, 1, 3, 6, 13, 17, 21, 31, 32, 33, 64, 81};
    sdel = '{0, 8, 5};
    n_chk = 0; n_fail = 0; finished = 0; lfsr = 8'hA5;
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    req_src = '0; req_dst = '0; req_len = '0; req_line_dw = '0; req_burst_dw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    // R6 R7: 81 bytes starting 31 before a 32-byte line -> 31, 32, 18
    run_case(32'h2000_0041, 32'h1000_0001, 81, 8, 16);
    // R5: mismatched low bits -> plain writes only
    run_case(32'h2000_0003, 32'h1000_0001, 81, 8, 16);
    for (int li = 0; li < 4; li++)
      for (int bi = 0; bi < 3; bi++)
        for (int d = 0; d < 40; d += 3)
          for (int si = 0; si < 3; si++)
            for (int ln = 0; ln < 12; ln++)
              run_case(32'h2000_0000 + d + sdel[si], 32'h1000_0000 + d, lens[ln],
                       lines[li], bursts[bi]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule